// File: doc/BRIEF.md
# Lane-packed pipelined adder tree

This block adds eight unsigned 5-bit values and produces their 8-bit total. It accepts a new set of values on every clock and returns one total per clock. The pipeline has three stages, so each total appears exactly three clocks after its inputs were presented.

The design does not build a tree of seven two-input adders. Each tree level uses one wide adder instead. Several narrow operands are packed side by side into one long word. Each lane carries a zero guard bit above its value. That guard bit absorbs the lane's carry, so the partial sums stay independent inside a single addition.

- Level one uses one 24-bit add to form four pair sums.
- Level two uses one 14-bit add to form two quad sums.
- Level three uses a plain 7-bit add to form the final total.

A valid flag travels with the data through the pipeline. Results are meaningful only on cycles where the output-valid flag is high.

Top module: `packed_sum8`

## Requirements
- R1: Level one places the even-numbered inputs (0, 2, 4, 6) and the odd-numbered inputs (1, 3, 5, 7) in ascending 6-bit lanes of two operand words. Each lane has a zero guard bit at positions 5, 11, 17 and 23. One 24-bit add gives lane k = input 2k + input 2k+1, with no carry crossing into the next lane.
- R2: Level two places pair sums 0 and 2 in one operand and pair sums 1 and 3 in the other, in 7-bit guarded lanes. One 14-bit add gives (sum0+sum1) and (sum2+sum3) independently, even when every pair sum is at its maximum of 62.
- R3: `out_sum` equals the arithmetic total of the eight input values, up to the maximum of 248 with all inputs at 31, without overflow. No adder operand is wider than 25 bits.
- R4: Latency is exactly 3 clocks. The block takes a new input set on every clock and delivers back-to-back results with no bubble.
- R5: `out_vld` is high in a cycle exactly when `in_vld` was high 3 clocks earlier, and low otherwise.
- R6: While `rst_n` is low (synchronous, active low), `out_vld` is forced low whatever `in_vld` does. After release, `out_vld` stays low until a valid input has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input set is valid this cycle |
| in_data | input | 40 | Eight unsigned 5-bit values; value i is at bits [5i+4:5i] |
| out_vld | output | 1 | `out_sum` is valid this cycle |
| out_sum | output | 8 | Total of the eight values from 3 clocks earlier |

## Verification
Two events can fall in the same cycle, and the bench provokes them together:

- One lane of a packed word reaches its largest sum.
- The neighbouring lane of the same word also reaches its largest sum.

When both happen, a missing or misplaced guard bit would let a carry leak from one lane into the next. The bench drives pair-maximum, quad-maximum and all-maximum vectors, so that neighbouring lanes saturate in the same addition. It also walks a single maximum value across every input position, which exposes any swap between lanes. Each total, and each result slot that carries a gap, is compared on every clock against a reference that sums the integers and delays them by three cycles, during back-to-back and gapped traffic alike.

// File: rtl/psum_pkg.sv
// Package psum_pkg
// Shared sizing for the lane-packed adder tree. All widths derive from
// the input width and the input count; the tree shape is fixed to
// three levels for eight inputs.
package psum_pkg;
    localparam int VAL_W     = 5;                       // bits per input value
    localparam int N_IN      = 8;                       // number of inputs
    localparam int L1_LANES  = N_IN / 2;                // pair sums
    localparam int L1_W      = VAL_W + 1;               // lane incl. guard
    localparam int L2_LANES  = L1_LANES / 2;            // quad sums
    localparam int L2_W      = L1_W + 1;                // lane incl. guard
    localparam int SUM_W     = L2_W + 1;                // final total width
    localparam int MAX_TOTAL = N_IN * ((1 << VAL_W) - 1);
    localparam int MAX_OPND  = 25;                      // widest adder allowed
endpackage

// File: rtl/psum_lane_add.sv
// Module psum_lane_add
// One tree level: packs 2*LANES narrow operands into two wide words,
// each lane topped by a zero guard bit, and adds them with a single
// adder. Operand A takes even-numbered inputs, operand B odd-numbered
// ones, both in ascending lane order. Output is registered.
// Assumes: inputs are unsigned; data registers load every cycle and
// are meaningful only when vld_o is high.
module psum_lane_add #(
    parameter int IN_W  = 5,
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vld_i,
    input  logic [2*LANES*IN_W-1:0]    vals_i,
    output logic                       vld_o,
    output logic [LANES*(IN_W+1)-1:0]  lanes_o
);
    localparam int LW     = IN_W + 1;
    localparam int WORD_W = LANES * LW;

    logic [WORD_W-1:0] op_a;
    logic [WORD_W-1:0] op_b;

    // Build the guarded operand words lane by lane.
    for (genvar k = 0; k < LANES; k++) begin : g_pack
        assign op_a[k*LW +: LW] = {1'b0, vals_i[(2*k)*IN_W   +: IN_W]};
        assign op_b[k*LW +: LW] = {1'b0, vals_i[(2*k+1)*IN_W +: IN_W]};
    end

    // Single wide addition and pipeline register for this level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            lanes_o <= '0;
        end else begin
            vld_o   <= vld_i;
            lanes_o <= op_a + op_b;
        end
    end

    // R1 / R2: each lane holds the exact sum of its two inputs, so no
    // carry leaked from the lane below.
    for (genvar k = 0; k < LANES; k++) begin : g_chk
        a_r1_lane_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(vld_i)) |->
            (lanes_o[k*LW +: LW] ==
             ({1'b0, $past(vals_i[(2*k)*IN_W +: IN_W])} +
              {1'b0, $past(vals_i[(2*k+1)*IN_W +: IN_W])})))
            else $error("level lane %0d sum corrupted", k);
    end
endmodule

// File: rtl/psum_final.sv
// Module psum_final
// Last tree level: an ordinary adder combines the two quad sums into
// the final total, followed by the output register.
// Assumes: the two lanes arrive packed, low lane in the low bits.
module psum_final #(
    parameter int IN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [2*IN_W-1:0] lanes_i,
    output logic              vld_o,
    output logic [IN_W:0]     sum_o
);
    logic [IN_W:0] lo_ext;
    logic [IN_W:0] hi_ext;

    // Zero-extend both lanes to the result width.
    always_comb begin
        lo_ext = {1'b0, lanes_i[0    +: IN_W]};
        hi_ext = {1'b0, lanes_i[IN_W +: IN_W]};
    end

    // Final addition and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            sum_o <= '0;
        end else begin
            vld_o <= vld_i;
            sum_o <= lo_ext + hi_ext;
        end
    end

    // R3: the registered total matches the two lanes seen one clock earlier.
    a_r3_final_add: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vld_i)) |->
        (int'(sum_o) == int'($past(lanes_i[0 +: IN_W])) + int'($past(lanes_i[IN_W +: IN_W]))))
        else $error("final add mismatch");
endmodule

// File: rtl/packed_sum8.sv
// Module packed_sum8
// Sums eight unsigned 5-bit values per clock through three pipelined
// levels: a 24-bit lane-packed add, a 14-bit lane-packed add, and a
// plain 7-bit add. Latency is three clocks; throughput one per clock.
// Assumes: in_data value i sits at bits [5i+4:5i].
module packed_sum8
    import psum_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic [N_IN*VAL_W-1:0]  in_data,
    output logic                   out_vld,
    output logic [SUM_W-1:0]       out_sum
);
    localparam int L1_WORD = L1_LANES * L1_W;
    localparam int L2_WORD = L2_LANES * L2_W;

    logic               v1, v2;
    logic [L1_WORD-1:0] pair_sums;
    logic [L2_WORD-1:0] quad_sums;

    // Level one: four pair sums from one 24-bit add.
    psum_lane_add #(.IN_W(VAL_W), .LANES(L1_LANES)) u_lvl1 (
        .clk(clk), .rst_n(rst_n), .vld_i(in_vld), .vals_i(in_data),
        .vld_o(v1), .lanes_o(pair_sums)
    );

    // Level two: two quad sums from one 14-bit add.
    psum_lane_add #(.IN_W(L1_W), .LANES(L2_LANES)) u_lvl2 (
        .clk(clk), .rst_n(rst_n), .vld_i(v1), .vals_i(pair_sums),
        .vld_o(v2), .lanes_o(quad_sums)
    );

    // Level three: plain add to the final total.
    psum_final #(.IN_W(L2_W)) u_lvl3 (
        .clk(clk), .rst_n(rst_n), .vld_i(v2), .lanes_i(quad_sums),
        .vld_o(out_vld), .sum_o(out_sum)
    );

    // Cycles since reset release, saturating at the pipeline depth.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R5: the output flag follows the input flag after exactly three clocks.
    a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_vld == $past(in_vld, 3)))
        else $error("valid latency broken");

    // R3: a valid total never exceeds the largest possible sum.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (int'(out_sum) <= MAX_TOTAL))
        else $error("total out of range");

    // R6: the output flag is low in the first cycle after a reset cycle.
    a_r6_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_vld)
        else $error("valid not cleared by reset");

    // R3: the widest packed operand stays within the allowed adder width.
    initial begin
        a_r3_operand_width: assert (L1_WORD <= MAX_OPND && L2_WORD <= MAX_OPND)
            else $error("operand too wide");
    end
endmodule

// File: tb/tb_packed_sum8.sv
module tb_packed_sum8;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic [39:0] in_data;
    logic        out_vld;
    logic [7:0]  out_sum;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    bit    hv [3];
    int    hs [3];
    string ht [3];

    always #5 clk = ~clk;

    packed_sum8 dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .out_vld(out_vld), .out_sum(out_sum)
    );

    function automatic int ref_total(input logic [39:0] d);
        int t = 0;
        for (int i = 0; i < 8; i++) t += int'(d[i*5 +: 5]);
        return t;
    endfunction

    // Check outputs against the model slot from 3 steps ago, then drive.
    task automatic step(input bit v, input logic [39:0] d, input string tag);
        @(negedge clk);
        checks++;
        if (out_vld !== hv[2]) begin
            errors++;
            $display("FAIL R5 out_vld actual %0b expected %0b", out_vld, hv[2]);
        end
        if (hv[2]) begin
            checks++;
            if (out_sum !== hs[2][7:0]) begin
                errors++;
                $display("FAIL %s out_sum actual %0d expected %0d", ht[2], out_sum, hs[2]);
            end
        end
        hv[2] = hv[1]; hs[2] = hs[1]; ht[2] = ht[1];
        hv[1] = hv[0]; hs[1] = hs[0]; ht[1] = ht[0];
        hv[0] = v; hs[0] = ref_total(d); ht[0] = tag;
        in_vld  = v;
        in_data = d;
    endtask

    function automatic logic [39:0] rnd40();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        for (int i = 0; i < 3; i++) begin hv[i] = 0; hs[i] = 0; ht[i] = ""; end
        rst_n = 1'b0; in_vld = 1'b1; in_data = '1;
        repeat (4) @(negedge clk);
        // R6: valid held low during reset despite valid input
        checks++;
        if (out_vld !== 1'b0) begin
            errors++; $display("FAIL R6 out_vld in reset actual %0b expected 0", out_vld);
        end
        in_vld = 1'b0; in_data = '0;
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (out_vld !== 1'b0) begin
            errors++; $display("FAIL R6 out_vld after reset actual %0b expected 0", out_vld);
        end
        // R1: single maximum value walked over every input position
        for (int i = 0; i < 8; i++) step(1'b1, 40'd31 << (i*5), "R1");
        // R1: one small value per position to expose lane swaps
        for (int i = 0; i < 8; i++) step(1'b1, 40'(i+1) << (i*5), "R1");
        // R2: saturated pairs, then saturated quads
        for (int k = 0; k < 4; k++) step(1'b1, 40'h3FF << (k*10), "R2");
        step(1'b1, 40'h00000FFFFF, "R2");
        step(1'b1, 40'hFFFFF00000, "R2");
        // R3: all maximum gives 248; all zero gives 0
        step(1'b1, '1, "R3");
        step(1'b1, '0, "R3");
        step(1'b1, '1, "R3");
        // R4: back-to-back random vectors on every clock
        for (int n = 0; n < 60; n++) step(1'b1, rnd40(), "R4");
        // R5: random vectors with random gaps
        for (int n = 0; n < 120; n++) step(1'($urandom_range(0, 1)), rnd40(), "R5");
        // drain
        for (int n = 0; n < 4; n++) step(1'b0, rnd40(), "R5");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule